// File: doc/BRIEF.md
# Compare-register branch condition unit

This block keeps the status state of a small byte-oriented virtual machine and decides conditional branches from it. The state is a carry bit and two byte-wide compare registers, called here the first and second compare register. The machine has no sign, zero or overflow flags. Each status-changing operation loads the two compare registers. A conditional branch then compares the two stored bytes directly, either as signed or as unsigned numbers.

The surrounding datapath raises an update strobe for one cycle. With the strobe it gives an operation class, the two operands, the raw result (up to twice the data width) and the carry-out of the arithmetic. The new state is visible from the following cycle. At any time the datapath can present a branch opcode. The branch-taken output is a purely combinational function of that opcode and the registered compare state, so it is valid in the same cycle.

A wide result is folded into one byte by OR-ing its upper and lower halves. After that, only the equal and not-equal branches carry meaning.

Top module: `ccu_top`

## Requirements
- R1: After reset both compare registers and the carry bit read 0.
- R2: An update with class code 0 (plain result) loads the first compare register with the low byte of the result and clears the second. The carry bit is left as it was.
- R3: An update with class code 1 (wide result) loads the first compare register with the bitwise OR of the result's high byte and low byte, and clears the second. The carry bit is left as it was.
- R4: An update with class code 2 (compare) loads the first compare register with operand A and the second with operand B. The carry bit is left as it was.
- R5: Class code 3 sets the carry bit and class code 4 clears it. Neither touches the compare registers.
- R6: An update with class code 5 (carry arithmetic) loads the first compare register with the low byte of the result, clears the second, and loads the carry bit from the carry input.
- R7: With the strobe low, or with class code 6 or 7, none of the three state values changes, whatever the other inputs carry.
- R8: Branch opcode 0x9c is always taken.
- R9: Opcode 0x9d is taken when the two compare registers are equal. Opcode 0x9e is taken when they differ.
- R10: Treating both compare registers as signed, the branch is taken when the first is greater (0x9f), greater or equal (0xa0), less (0xa1), or less or equal (0xa2) compared with the second.
- R11: Treating both compare registers as unsigned, the branch is taken when the first is higher (0xa3), higher or same (0xa4), lower (0xa5), or lower or same (0xa6) compared with the second.
- R12: Any branch opcode outside 0x9c to 0xa6 gives branch-taken low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Status update strobe |
| op_class_i | input | 3 | Operation class code |
| opa_i | input | DW | First operand |
| opb_i | input | DW | Second operand |
| res_i | input | 2*DW | Raw operation result |
| carry_i | input | 1 | Carry-out or borrow of the operation |
| br_op_i | input | 8 | Branch opcode to evaluate |
| cmp1_o | output | DW | First compare register |
| cmp2_o | output | DW | Second compare register |
| dc_o | output | 1 | Carry bit |
| taken_o | output | 1 | Branch condition met |

## Verification
The assertions assume that every input is a known value once reset is released. They also assume that the datapath holds the strobe for exactly the cycle it wants recorded; a strobe held longer repeats the update. The stimulus drives all inputs on the falling edge. It lowers the strobe shortly after the rising edge that captures it. It places class codes 6 and 7 and strobe-low cycles alongside busy operand and result values, so the hold properties are tested against live data rather than idle zeros.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [2:0] {
        CLS_RES8  = 3'd0,
        CLS_RES16 = 3'd1,
        CLS_CMP   = 3'd2,
        CLS_DCSET = 3'd3,
        CLS_DCCLR = 3'd4,
        CLS_CARRY = 3'd5
    } op_class_e;

    // Condition slots, in opcode order starting at BR_FIRST
    localparam int COND_ALWAYS = 0;
    localparam int COND_EQ     = 1;
    localparam int COND_NE     = 2;
    localparam int COND_SGT    = 3;
    localparam int COND_SGE    = 4;
    localparam int COND_SLT    = 5;
    localparam int COND_SLE    = 6;
    localparam int COND_UHI    = 7;
    localparam int COND_UHS    = 8;
    localparam int COND_ULO    = 9;
    localparam int COND_ULS    = 10;
    localparam int NUM_COND    = 11;

    localparam logic [OPC_W-1:0] BR_FIRST = 8'h9c;
    localparam logic [OPC_W-1:0] BR_LAST  = BR_FIRST + OPC_W'(NUM_COND - 1);

endpackage

// File: rtl/ccu_fold.sv
module ccu_fold #(
    parameter int DW    = 8,
    parameter int LANES = 2
) (
    input  logic [LANES*DW-1:0] wide_i,
    output logic [DW-1:0]       narrow_o
);

    logic [DW-1:0] part [LANES];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_first
                assign part[g] = wide_i[DW-1:0];
            end else begin : g_rest
                assign part[g] = part[g-1] | wide_i[g*DW +: DW];
            end
        end
    endgenerate

    assign narrow_o = part[LANES-1];

endmodule

// File: rtl/ccu_state.sv
module ccu_state
    import ccu_pkg::*;
#(
    parameter int DW = 8,
    localparam int RW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [2:0]    cls_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic [RW-1:0] res_i,
    input  logic          carry_i,
    output logic [DW-1:0] cmp1_q,
    output logic [DW-1:0] cmp2_q,
    output logic          dc_q
);

    typedef struct packed {
        logic [DW-1:0] cmp1;
        logic [DW-1:0] cmp2;
        logic          dc;
    } st_t;

    st_t           st_d, st_q;
    logic [DW-1:0] folded;

    ccu_fold #(.DW(DW), .LANES(2)) i_fold (
        .wide_i   (res_i),
        .narrow_o (folded)
    );

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            case (cls_i)
                CLS_RES8: begin
                    st_d.cmp1 = res_i[DW-1:0];
                    st_d.cmp2 = '0;
                end
                CLS_RES16: begin
                    st_d.cmp1 = folded;
                    st_d.cmp2 = '0;
                end
                CLS_CMP: begin
                    st_d.cmp1 = opa_i;
                    st_d.cmp2 = opb_i;
                end
                CLS_DCSET: st_d.dc = 1'b1;
                CLS_DCCLR: st_d.dc = 1'b0;
                CLS_CARRY: begin
                    st_d.cmp1 = res_i[DW-1:0];
                    st_d.cmp2 = '0;
                    st_d.dc   = carry_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp1_q = st_q.cmp1;
    assign cmp2_q = st_q.cmp2;
    assign dc_q   = st_q.dc;

    p_res8_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && cls_i == CLS_RES8) |=>
            (cmp1_q == $past(res_i[DW-1:0]) && cmp2_q == '0 && $stable(dc_q)));

    p_res16_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && cls_i == CLS_RES16) |=>
            (cmp1_q == ($past(res_i[RW-1:DW]) | $past(res_i[DW-1:0])) && cmp2_q == '0
             && $stable(dc_q)));

    p_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && cls_i == CLS_CMP) |=>
            (cmp1_q == $past(opa_i) && cmp2_q == $past(opb_i) && $stable(dc_q)));

    p_dcset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && cls_i == CLS_DCSET) |=> (dc_q && $stable(cmp1_q) && $stable(cmp2_q)));

    p_dcclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && cls_i == CLS_DCCLR) |=> (!dc_q && $stable(cmp1_q) && $stable(cmp2_q)));

    p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && cls_i == CLS_CARRY) |=>
            (cmp1_q == $past(res_i[DW-1:0]) && cmp2_q == '0 && dc_q == $past(carry_i)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i || cls_i > 3'd5) |=>
            ($stable(cmp1_q) && $stable(cmp2_q) && $stable(dc_q)));

endmodule

// File: rtl/ccu_cond_eval.sv
module ccu_cond_eval
    import ccu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    cmp1_i,
    input  logic [DW-1:0]    cmp2_i,
    input  logic [OPC_W-1:0] opc_i,
    output logic             taken_o
);

    logic                eq, ult, slt;
    logic [NUM_COND-1:0] cond;
    logic [NUM_COND-1:0] hit;

    always_comb begin
        eq  = (cmp1_i == cmp2_i);
        ult = (cmp1_i < cmp2_i);
        slt = ($signed(cmp1_i) < $signed(cmp2_i));

        cond              = '0;
        cond[COND_ALWAYS] = 1'b1;
        cond[COND_EQ]     = eq;
        cond[COND_NE]     = !eq;
        cond[COND_SGT]    = !slt && !eq;
        cond[COND_SGE]    = !slt;
        cond[COND_SLT]    = slt;
        cond[COND_SLE]    = slt || eq;
        cond[COND_UHI]    = !ult && !eq;
        cond[COND_UHS]    = !ult;
        cond[COND_ULO]    = ult;
        cond[COND_ULS]    = ult || eq;
    end

    generate
        for (genvar g = 0; g < NUM_COND; g++) begin : g_slot
            assign hit[g] = (opc_i == (BR_FIRST + OPC_W'(g))) && cond[g];
        end
    endgenerate

    assign taken_o = |hit;

    p_outside_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_i < BR_FIRST || opc_i > BR_LAST) |-> !taken_o);

    p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_i == BR_FIRST) |-> taken_o);

    p_eqne_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_i == 8'h9d || opc_i == 8'h9e) |->
            (taken_o == ((cmp1_i == cmp2_i) == (opc_i == 8'h9d))));

    p_strict_equal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc_i == 8'h9f || opc_i == 8'ha1) && cmp1_i == cmp2_i) |-> !taken_o);

    p_loose_equal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc_i == 8'ha0 || opc_i == 8'ha2) && cmp1_i == cmp2_i) |-> taken_o);

    p_lower_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_i == 8'ha5 && cmp2_i == '0) |-> !taken_o);

    p_hs_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_i == 8'ha4 && cmp2_i == '0) |-> taken_o);

endmodule

// File: rtl/ccu_top.sv
module ccu_top
    import ccu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_i,
    input  logic [2:0]      op_class_i,
    input  logic [DW-1:0]   opa_i,
    input  logic [DW-1:0]   opb_i,
    input  logic [2*DW-1:0] res_i,
    input  logic            carry_i,
    input  logic [7:0]      br_op_i,
    output logic [DW-1:0]   cmp1_o,
    output logic [DW-1:0]   cmp2_o,
    output logic            dc_o,
    output logic            taken_o
);

    logic [DW-1:0] cmp1_q, cmp2_q;
    logic          dc_q;

    ccu_state #(.DW(DW)) i_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd_i),
        .cls_i   (op_class_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .res_i   (res_i),
        .carry_i (carry_i),
        .cmp1_q  (cmp1_q),
        .cmp2_q  (cmp2_q),
        .dc_q    (dc_q)
    );

    ccu_cond_eval #(.DW(DW)) i_eval (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp1_i  (cmp1_q),
        .cmp2_i  (cmp2_q),
        .opc_i   (br_op_i),
        .taken_o (taken_o)
    );

    assign cmp1_o = cmp1_q;
    assign cmp2_o = cmp2_q;
    assign dc_o   = dc_q;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cmp1_o == '0 && cmp2_o == '0 && !dc_o));

endmodule

// File: tb/test_ccu_top.sv
module test_ccu_top;

    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            upd_i = 1'b0;
    logic [2:0]      op_class_i = '0;
    logic [DW-1:0]   opa_i = '0;
    logic [DW-1:0]   opb_i = '0;
    logic [2*DW-1:0] res_i = '0;
    logic            carry_i = 1'b0;
    logic [7:0]      br_op_i = '0;
    logic [DW-1:0]   cmp1_o, cmp2_o;
    logic            dc_o, taken_o;

    ccu_top #(.DW(DW)) i_ccu_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (upd_i),
        .op_class_i (op_class_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .res_i      (res_i),
        .carry_i    (carry_i),
        .br_op_i    (br_op_i),
        .cmp1_o     (cmp1_o),
        .cmp2_o     (cmp2_o),
        .dc_o       (dc_o),
        .taken_o    (taken_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit            is_br;
        logic [DW-1:0] c1;
        logic [DW-1:0] c2;
        logic          dc;
        logic          tk;
        int            req;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the state
    logic [DW-1:0] m_c1 = '0, m_c2 = '0;
    logic          m_dc = 1'b0;

    function automatic logic exp_taken(input logic [7:0] op, input logic [7:0] a,
                                       input logic [7:0] b);
        case (op)
            8'h9c:   return 1'b1;
            8'h9d:   return a == b;
            8'h9e:   return a != b;
            8'h9f:   return $signed(a) >  $signed(b);
            8'ha0:   return $signed(a) >= $signed(b);
            8'ha1:   return $signed(a) <  $signed(b);
            8'ha2:   return $signed(a) <= $signed(b);
            8'ha3:   return a >  b;
            8'ha4:   return a >= b;
            8'ha5:   return a <  b;
            8'ha6:   return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int req_of(input logic [7:0] op);
        if (op == 8'h9c) return 8;
        if (op == 8'h9d || op == 8'h9e) return 9;
        if (op >= 8'h9f && op <= 8'ha2) return 10;
        if (op >= 8'ha3 && op <= 8'ha6) return 11;
        return 12;
    endfunction

    function automatic void push_state(input int req);
        item_t it;
        it.is_br = 1'b0; it.c1 = m_c1; it.c2 = m_c2; it.dc = m_dc; it.tk = 1'b0;
        it.req = req;
        q.push_back(it);
    endfunction

    task automatic upd(input logic [2:0] cls, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] r, input logic c, input bit strobe, input int req);
        @(negedge clk);
        upd_i = strobe; op_class_i = cls; opa_i = a; opb_i = b; res_i = r; carry_i = c;
        @(posedge clk);
        #1;
        upd_i = 1'b0;
        if (strobe) begin
            case (cls)
                3'd0: begin m_c1 = r[7:0]; m_c2 = '0; end
                3'd1: begin m_c1 = r[15:8] | r[7:0]; m_c2 = '0; end
                3'd2: begin m_c1 = a; m_c2 = b; end
                3'd3: m_dc = 1'b1;
                3'd4: m_dc = 1'b0;
                3'd5: begin m_c1 = r[7:0]; m_c2 = '0; m_dc = c; end
                default: ;
            endcase
        end
        push_state(req);
    endtask

    task automatic br(input logic [7:0] op);
        item_t it;
        @(negedge clk);
        br_op_i = op;
        @(posedge clk);
        #1;
        it.is_br = 1'b1; it.c1 = m_c1; it.c2 = m_c2; it.dc = m_dc;
        it.tk = exp_taken(op, m_c1, m_c2);
        it.req = req_of(op);
        q.push_back(it);
    endtask

    // sweep every branch opcode plus neighbours: R8 R9 R10 R11 R12
    task automatic sweep();
        for (int op = 8'h9a; op <= 8'ha8; op++) br(8'(op));
        br(8'h00);
        br(8'hff);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (it.is_br) begin
                    if (taken_o !== it.tk) begin
                        n_bad++;
                        $display("FAIL R%0d: op=%h c1=%h c2=%h taken actual=%b expected=%b",
                                 it.req, br_op_i, it.c1, it.c2, taken_o, it.tk);
                    end
                end else if (cmp1_o !== it.c1 || cmp2_o !== it.c2 || dc_o !== it.dc) begin
                    n_bad++;
                    $display("FAIL R%0d: state actual=%h/%h/%b expected=%h/%h/%b",
                             it.req, cmp1_o, cmp2_o, dc_o, it.c1, it.c2, it.dc);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        push_state(1);                                           // R1 reset values
        @(negedge clk);
        rst_n = 1'b1;
        upd(3'd6, 8'h11, 8'h22, 16'hbeef, 1'b1, 1'b0, 1);        // R1 still zero after release

        upd(3'd0, 8'h00, 8'h00, 16'h775a, 1'b1, 1'b1, 2);        // R2 plain result
        sweep();
        upd(3'd3, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b1, 5);        // R5 set carry
        upd(3'd0, 8'h00, 8'h00, 16'h00c3, 1'b0, 1'b1, 2);        // R2 carry kept
        upd(3'd1, 8'h00, 8'h00, 16'h1200, 1'b0, 1'b1, 3);        // R3 wide result
        upd(3'd1, 8'h00, 8'h00, 16'ha05c, 1'b0, 1'b1, 3);        // R3 fold
        upd(3'd1, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b1, 3);        // R3 zero
        br(8'h9d);                                               // R9 equal after zero fold
        br(8'h9e);                                               // R9
        upd(3'd2, 8'h80, 8'h7f, 16'h0000, 1'b0, 1'b1, 4);        // R4 compare
        sweep();
        upd(3'd2, 8'h10, 8'h10, 16'hffff, 1'b0, 1'b1, 4);        // R4 equal pair
        sweep();
        upd(3'd2, 8'hff, 8'h01, 16'h0000, 1'b0, 1'b1, 4);        // R4 -1 vs 1
        sweep();
        upd(3'd2, 8'h05, 8'hfe, 16'h0000, 1'b0, 1'b1, 4);        // R4
        sweep();
        upd(3'd4, 8'h33, 8'h44, 16'h5555, 1'b1, 1'b1, 5);        // R5 clear carry
        upd(3'd5, 8'h00, 8'h00, 16'h01ff, 1'b1, 1'b1, 6);        // R6 carry in
        upd(3'd5, 8'h00, 8'h00, 16'h0034, 1'b0, 1'b1, 6);        // R6 carry out 0
        upd(3'd2, 8'h3c, 8'h9a, 16'h0000, 1'b0, 1'b1, 4);        // R4
        upd(3'd0, 8'haa, 8'hbb, 16'h1234, 1'b1, 1'b0, 7);        // R7 strobe low
        upd(3'd6, 8'haa, 8'hbb, 16'h1234, 1'b1, 1'b1, 7);        // R7 class 6
        upd(3'd7, 8'h01, 8'h02, 16'hffff, 1'b0, 1'b1, 7);        // R7 class 7
        upd(3'd3, 8'h01, 8'h02, 16'hffff, 1'b0, 1'b0, 7);        // R7 set ignored
        sweep();
        repeat (2) @(posedge clk);
        #6;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule